// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the rate of an intermediate-frequency signal by counting its rising edges inside a gate window of known length. The resulting 20-bit value is read by software to find where a tuning scan should stop. Either of two input pins can be chosen as the count source. When the analog front end is powered down, the chosen source reads as low, so nothing is counted.

In automatic mode a start command clears the result and arms the gate. The gate opens on the next pulse of a 1 kHz timebase and stays open for 1, 4, 16 or 64 timebase pulses. The window is therefore aligned to the timebase. In manual mode, software opens and closes the gate itself, and the timebase has no effect. In both modes the result holds after the gate closes, until the next measurement begins. The result saturates at its largest value, and a sticky flag marks that it did.

The count input is brought into the clock domain through a synchronizer before its edges are detected. The system clock must therefore be at least four times the highest input rate, so that each input level lasts two or more clock periods.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, count is 0 and busy, done and ovf are all 0.
- R2: In automatic mode (man_mode = 0), a start pulse seen while idle has these effects on the next clock edge: count is cleared, ovf is cleared, done is cleared and busy is set. The gate opens on the next ms_tick pulse after that.
- R3: gate_sel selects the window length in timebase pulses: 0 gives 1, 1 gives 4, 2 gives 16 and 3 gives 64. The window counts the pulse that opens the gate as its first pulse. On the timebase pulse that follows the last pulse of the window, busy clears and done is set.
- R4: While the gate is open, count increases by one for each rising edge of the selected source: sig_a when src_sel = 0, sig_b when src_sel = 1. Edges on the other source are ignored. Each high level and each low level of the input must last at least two clock periods.
- R5: While busy is low, count does not change, whatever happens on the inputs. Done stays high until the next measurement starts.
- R6: If an edge arrives while count is 2^CNT_W−1, count stays at that value and ovf is set. Ovf stays high until the next measurement starts.
- R7: While analog_on = 0, the selected source is treated as low and no edges are counted.
- R8: In manual mode (man_mode = 1), a man_open pulse seen while idle does three things on the next edge: it clears count, sets busy and opens the gate. The gate stays open across any number of ms_tick pulses. A man_close pulse closes it, clears busy and sets done.
- R9: These commands are ignored: start while busy, start in manual mode, and man_open in automatic mode.
- R10: Busy and done are never high together. While busy, count never decreases and never rises by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle timebase pulse at 1 kHz |
| sig_a | input | 1 | Count source 0 |
| sig_b | input | 1 | Count source 1 |
| src_sel | input | 1 | Source select: 0 sig_a, 1 sig_b |
| analog_on | input | 1 | Front end powered; 0 forces the source low |
| gate_sel | input | SEL_W | Automatic window length select |
| start | input | 1 | Start an automatic measurement |
| man_mode | input | 1 | 1 selects manual gate control |
| man_open | input | 1 | Open the gate in manual mode |
| man_close | input | 1 | Close the gate in manual mode |
| count | output | CNT_W | Edge count result |
| busy | output | 1 | Measurement armed or gate open |
| done | output | 1 | Measurement finished, result valid |
| ovf | output | 1 | Count saturated |

## Verification
Some properties are checked by assertions on every cycle. Busy and done must never be high together. Count must hold while idle and must climb by at most one per clock while busy. Ovf must only ever be seen with count at full scale. Done may rise only as busy falls, and may fall only as busy rises. Other behaviour can only be shown by the bench's scenarios. These are the window length for each gate_sel setting, alignment of the window to the timebase, the choice between the two sources, silencing of the input when the front end is off, and manual gates that span several timebase pulses. The scenarios also cover commands that are ignored and saturation of a narrow counter.

// File: rtl/gfc_pkg.sv
`timescale 1ns/1ps
package gfc_pkg;

   typedef enum logic [1:0] {
      GS_IDLE  = 2'd0,
      GS_ARMED = 2'd1,
      GS_OPEN  = 2'd2
   } gate_state_t;

   // number of timebase pulses in a window for a given select code
   function automatic int unsigned window_ticks(input int unsigned sel_code,
                                                input int unsigned step_log2);
      return 32'd1 << (step_log2 * sel_code);
   endfunction

endpackage

// File: rtl/gfc_input_cond.sv
`timescale 1ns/1ps
module gfc_input_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_a,
   input  logic sig_b,
   input  logic src_sel,
   input  logic analog_on,
   output logic rise
);

   logic raw;
   logic synced;
   logic prev_q;

   // powered-down front end reads as a steady low
   assign raw = analog_on & (src_sel ? sig_b : sig_a);

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q <= '0;
            end else begin
               stg_q[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  stg_q[i] <= stg_q[i-1];
               end
            end
         end
         assign synced = stg_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= synced;
   end

   assign rise = synced & ~prev_q;

endmodule

// File: rtl/gfc_gate_ctrl.sv
`timescale 1ns/1ps
module gfc_gate_ctrl
   import gfc_pkg::*;
#(
   parameter int SEL_W          = 2,
   parameter int GATE_STEP_LOG2 = 2,
   parameter int TICK_W         = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic [SEL_W-1:0] gate_sel,
   input  logic             start,
   input  logic             man_mode,
   input  logic             man_open,
   input  logic             man_close,
   output logic             clr,
   output logic             gate_open,
   output logic             busy,
   output logic             done
);

   gate_state_t       state_q;
   logic [TICK_W-1:0] tick_cnt_q;
   logic [TICK_W-1:0] target_q;
   logic              manual_q;
   logic              done_q;
   logic              start_ok;
   logic              mopen_ok;
   logic              last_tick;

   assign start_ok  = start & ~man_mode & (state_q == GS_IDLE);
   assign mopen_ok  = man_open & man_mode & (state_q == GS_IDLE);
   assign last_tick = ms_tick & ((tick_cnt_q + TICK_W'(1)) == target_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= GS_IDLE;
         tick_cnt_q <= '0;
         target_q   <= '0;
         manual_q   <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         case (state_q)
            GS_IDLE: begin
               if (start_ok) begin
                  state_q    <= GS_ARMED;
                  tick_cnt_q <= '0;
                  target_q   <= TICK_W'(window_ticks(int'(gate_sel), GATE_STEP_LOG2));
                  manual_q   <= 1'b0;
                  done_q     <= 1'b0;
               end else if (mopen_ok) begin
                  state_q    <= GS_OPEN;
                  manual_q   <= 1'b1;
                  done_q     <= 1'b0;
               end
            end
            GS_ARMED: begin
               if (ms_tick) state_q <= GS_OPEN;
            end
            GS_OPEN: begin
               if (manual_q) begin
                  if (man_close) begin
                     state_q <= GS_IDLE;
                     done_q  <= 1'b1;
                  end
               end else if (last_tick) begin
                  state_q <= GS_IDLE;
                  done_q  <= 1'b1;
               end else if (ms_tick) begin
                  tick_cnt_q <= tick_cnt_q + TICK_W'(1);
               end
            end
            default: state_q <= GS_IDLE;
         endcase
      end
   end

   assign clr       = start_ok | mopen_ok;
   assign gate_open = (state_q == GS_OPEN);
   assign busy      = (state_q != GS_IDLE);
   assign done      = done_q;

endmodule

// File: rtl/gfc_sat_counter.sv
`timescale 1ns/1ps
module gfc_sat_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] FULL = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (inc) begin
         if (count == FULL) ovf <= 1'b1;
         else               count <= count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/gated_freq_counter.sv
`timescale 1ns/1ps
module gated_freq_counter #(
   parameter int CNT_W          = 20,
   parameter int SYNC_STAGES    = 2,
   parameter int SEL_W          = 2,
   parameter int GATE_STEP_LOG2 = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             sig_a,
   input  logic             sig_b,
   input  logic             src_sel,
   input  logic             analog_on,
   input  logic [SEL_W-1:0] gate_sel,
   input  logic             start,
   input  logic             man_mode,
   input  logic             man_open,
   input  logic             man_close,
   output logic [CNT_W-1:0] count,
   output logic             busy,
   output logic             done,
   output logic             ovf
);

   localparam int MAX_SHIFT = GATE_STEP_LOG2 * ((1 << SEL_W) - 1);
   localparam int MAX_TICKS = 1 << MAX_SHIFT;
   localparam int TICK_W    = $clog2(MAX_TICKS + 1);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("gated_freq_counter: CNT_W out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("gated_freq_counter: SYNC_STAGES out of range");
      end
      if (MAX_SHIFT > 20) begin : g_bad_gate
         $error("gated_freq_counter: longest window too large");
      end
   endgenerate

   logic rise;
   logic clr;
   logic gate_open;

   gfc_input_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .sig_a     (sig_a),
      .sig_b     (sig_b),
      .src_sel   (src_sel),
      .analog_on (analog_on),
      .rise      (rise)
   );

   gfc_gate_ctrl #(
      .SEL_W          (SEL_W),
      .GATE_STEP_LOG2 (GATE_STEP_LOG2),
      .TICK_W         (TICK_W)
   ) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .ms_tick   (ms_tick),
      .gate_sel  (gate_sel),
      .start     (start),
      .man_mode  (man_mode),
      .man_open  (man_open),
      .man_close (man_close),
      .clr       (clr),
      .gate_open (gate_open),
      .busy      (busy),
      .done      (done)
   );

   gfc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (gate_open & rise),
      .count (count),
      .ovf   (ovf)
   );

endmodule

// File: rtl/gfc_checker.sv
`timescale 1ns/1ps
module gfc_checker #(
   parameter int CNT_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             busy,
   input logic             done,
   input logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_FULL = '1;

   assert_busy_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (busy || $stable(count)));

   assert_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (count >= $past(count)));

   assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ({1'b0, count} <= ({1'b0, $past(count)} + 1'b1)));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (count == CNT_FULL));

   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> (ovf || busy));

   assert_done_at_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

   assert_done_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done) |-> $rose(busy));

endmodule

bind gated_freq_counter gfc_checker #(.CNT_W(CNT_W)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .count (count),
   .busy  (busy),
   .done  (done),
   .ovf   (ovf)
);

// File: tb/gated_freq_counter_tb_top.sv
`timescale 1ns/1ps
module gated_freq_counter_tb_top;

   localparam int CNT_W    = 20;
   localparam int SMALL_W  = 6;
   localparam int TICK_P   = 200;

   typedef struct {
      int    cnt;
      bit    ov;
      int    ticks;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b0;
   logic sig_a = 1'b0, sig_b = 1'b0;
   logic src_sel = 1'b0, analog_on = 1'b1;
   logic [1:0] gate_sel = 2'd0;
   logic start = 1'b0, man_mode = 1'b0, man_open = 1'b0, man_close = 1'b0;

   logic [CNT_W-1:0]   count;
   logic               busy, done, ovf;
   logic [SMALL_W-1:0] s_count;
   logic               s_busy, s_done, s_ovf;

   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;
   bit   excl_bad = 1'b0;
   exp_t exp_q[$];

   always #10 clk = ~clk;   // 20 ns period, 50 MHz

   gated_freq_counter #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sig_a(sig_a), .sig_b(sig_b),
      .src_sel(src_sel), .analog_on(analog_on), .gate_sel(gate_sel), .start(start),
      .man_mode(man_mode), .man_open(man_open), .man_close(man_close),
      .count(count), .busy(busy), .done(done), .ovf(ovf));

   gated_freq_counter #(.CNT_W(SMALL_W)) small_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sig_a(sig_a), .sig_b(sig_b),
      .src_sel(src_sel), .analog_on(analog_on), .gate_sel(gate_sel), .start(start),
      .man_mode(man_mode), .man_open(man_open), .man_close(man_close),
      .count(s_count), .busy(s_busy), .done(s_done), .ovf(s_ovf));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic wait_tick();
      @(posedge clk);
      while (ms_tick !== 1'b1) @(posedge clk);
   endtask

   // na pulses on sig_a and nb on sig_b, 3 clocks high, 3 clocks low
   task automatic emit(input int na, input int nb);
      int n = (na > nb) ? na : nb;
      for (int i = 0; i < n; i++) begin
         sig_a = (i < na);
         sig_b = (i < nb);
         repeat (3) @(negedge clk);
         sig_a = 1'b0;
         sig_b = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic run_auto(input int sel, input bit src, input int na, input int nb,
                           input int expc, input bit mid_start, input string req);
      exp_t e;
      e.cnt = expc; e.ov = 1'b0; e.ticks = 1 << (2 * sel); e.req = req;
      wait_tick();
      @(negedge clk);
      gate_sel = 2'(sel); src_sel = src; start = 1'b1;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b0;
      // R2: start clears result and raises busy one edge later
      check(busy == 1'b1, "R2", "busy after start", busy, 1);
      check(done == 1'b0, "R2", "done after start", done, 0);
      check(count == '0, "R2", "count after start", int'(count), 0);
      wait_tick();
      repeat (4) @(negedge clk);
      emit(na, nb);
      if (mid_start) begin
         start = 1'b1;          // R9: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      while (done !== 1'b1) @(posedge clk);
      @(negedge clk);
      emit(5, 5);
      repeat (8) @(negedge clk);
      // R5: result and done hold after the gate closes
      check(int'(count) == expc, "R5", "count held after done", int'(count), expc);
      check(done == 1'b1, "R5", "done held", done, 1);
   endtask

   // monitor: scoreboard pops expected results as done rises
   initial begin
      bit busy_prev = 1'b0;
      bit done_prev = 1'b0;
      int ticks_seen = 0;
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (busy && !busy_prev) ticks_seen = 0;
            if (busy && ms_tick) ticks_seen++;
            if (busy && done) excl_bad = 1'b1;
            if (done && !done_prev) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R3", "unexpected done", 1, 0);
               end else begin
                  e = exp_q.pop_front();
                  check(int'(count) == e.cnt, e.req, "count at done", int'(count), e.cnt);
                  check(ovf == e.ov, "R6", "ovf at done", ovf, int'(e.ov));
                  if (e.ticks >= 0)
                     check(ticks_seen == e.ticks, "R3", "window length in ticks",
                           ticks_seen, e.ticks);
               end
            end
            busy_prev = busy;
            done_prev = done;
         end
      end
   end

   // timebase generator
   initial begin
      @(posedge rst_n);
      forever begin
         repeat (TICK_P - 1) @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R10", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      exp_t e;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(count == '0, "R1", "count in reset", int'(count), 0);
      check(busy == 1'b0, "R1", "busy in reset", busy, 0);
      check(done == 1'b0, "R1", "done in reset", done, 0);
      check(ovf == 1'b0, "R1", "ovf in reset", ovf, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 / R3: sig_a selected, 1-tick window; sig_b edges ignored
      run_auto(0, 1'b0, 10, 7, 10, 1'b0, "R4");
      // R4: sig_b selected, 4-tick window
      run_auto(1, 1'b1, 5, 12, 12, 1'b0, "R4");
      // R9: 16-tick window, start repeated mid-window must not clear
      run_auto(2, 1'b0, 20, 0, 20, 1'b1, "R9");
      // R3: 64-tick window
      run_auto(3, 1'b1, 9, 3, 3, 1'b0, "R3");
      // R7: front end off, nothing counted
      analog_on = 1'b0;
      run_auto(0, 1'b0, 15, 15, 0, 1'b0, "R7");
      analog_on = 1'b1;

      // R6: narrow instance saturates, wide one counts on
      run_auto(1, 1'b0, 70, 0, 70, 1'b0, "R6");
      check(int'(s_count) == 63, "R6", "narrow count saturated", int'(s_count), 63);
      check(s_ovf == 1'b1, "R6", "narrow ovf set", s_ovf, 1);

      // R9: start ignored in manual mode
      @(negedge clk);
      man_mode = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R9", "start in manual mode", busy, 0);

      // R8: manual gate spanning several ticks
      e.cnt = 12; e.ov = 1'b0; e.ticks = -1; e.req = "R8";
      exp_q.push_back(e);
      man_open = 1'b1;
      @(negedge clk);
      man_open = 1'b0;
      check(busy == 1'b1, "R8", "busy after man_open", busy, 1);
      check(count == '0, "R8", "count cleared by man_open", int'(count), 0);
      repeat (3) @(negedge clk);
      emit(8, 2);
      repeat (3 * TICK_P) @(negedge clk);
      check(busy == 1'b1, "R8", "gate still open after ticks", busy, 1);
      emit(4, 0);
      repeat (10) @(negedge clk);
      man_close = 1'b1;
      @(negedge clk);
      man_close = 1'b0;
      check(done == 1'b1, "R8", "done after man_close", done, 1);
      check(busy == 1'b0, "R8", "busy after man_close", busy, 0);

      // R9: man_open ignored in automatic mode
      man_mode = 1'b0;
      @(negedge clk);
      man_open = 1'b1;
      @(negedge clk);
      man_open = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R9", "man_open in auto mode", busy, 0);
      check(int'(count) == 12, "R9", "count kept after ignored man_open", int'(count), 12);

      check(excl_bad == 1'b0, "R10", "busy and done together", int'(excl_bad), 0);
      check(exp_q.size() == 0, "R3", "results still pending", exp_q.size(), 0);
      finish_run();
   end

endmodule